// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a 32-bit effective address into a 32-bit real address by comparing it against every stored translation at once. Each of the sixteen slots holds a valid flag, an address-space flag, an 8-bit owner tag, a 4-bit page-size code, and a 20-bit effective and real page number. The lookup is purely combinational: the answer for a given set of lookup inputs appears in the same cycle they are presented.

A lookup supplies the effective address, a flag that tells instruction fetches from data accesses, the two address-space mode bits (one per access kind), and the current process ID. Each slot's page-size code moves the boundary between page number and page offset, so small and large pages can share the buffer. Slots are loaded through a single indexed write port. Walking page tables, choosing victims, permission checks and fault reporting are left to the surrounding logic.

Top module: `xlat_tlb_top`

## Requirements
- R1: While and after reset (rst_n low), every slot is invalid, so no lookup hits until a slot is written.
- R2: When wr_en is high at a rising clock edge, slot wr_idx takes all the wr_* fields, and lookups from the next cycle on see the new contents. Slots that are not written keep their contents.
- R3: A slot whose valid flag is 0 never matches.
- R4: A slot matches only if its space flag equals lk_ispace when lk_is_data is 0, or equals lk_dspace when lk_is_data is 1.
- R5: A slot matches only if its tag equals lk_pid, or its tag is 0, which makes it shared by every process.
- R6: Page-size code c gives a page of 4 KB times 4 to the power c. The offset is then 12+2c low address bits. Codes 10 to 15 all mean a 4 GB page, with no page-number bits compared. wr_epn and wr_rpn bit k stand for address bit 12+k, and only the bits at or above the offset width are compared.
- R7: On a hit, real_addr takes the matching slot's real page bits above the offset width and the effective address bits below it.
- R8: On a miss, hit, multi_hit, hit_idx and real_addr are all zero.
- R9: When several slots match, the lowest-numbered one supplies hit_idx and real_addr, and multi_hit is 1. With one match, multi_hit is 0.
- R10: The lookup outputs follow the lookup inputs and the stored slots within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_ea | input | 32 | Effective address to translate |
| lk_is_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| lk_ispace | input | 1 | Address-space mode bit used for instruction fetches |
| lk_dspace | input | 1 | Address-space mode bit used for data accesses |
| lk_pid | input | 8 | Current process ID |
| hit | output | 1 | Some slot matched |
| multi_hit | output | 1 | More than one slot matched |
| hit_idx | output | 4 | Index of the selected slot |
| real_addr | output | 32 | Translated address |
| wr_en | input | 1 | Load a slot at the next rising edge |
| wr_idx | input | 4 | Slot to load |
| wr_valid | input | 1 | Valid flag to store |
| wr_space | input | 1 | Address-space flag to store |
| wr_tag | input | 8 | Owner tag to store |
| wr_size | input | 4 | Page-size code to store |
| wr_epn | input | 20 | Effective page number to store (bit k is address bit 12+k) |
| wr_rpn | input | 20 | Real page number to store (bit k is address bit 12+k) |

## Verification
The hardest case to reach from the ports is several slots matching one address through different routes at the same time. That needs a large page and a small page that overlap, one slot owned by a process and one shared, and all of them in the right address space. Directed writes build such overlaps on purpose, with a small page at a higher index than a larger page that covers it. A random phase then draws page numbers, tags and size codes from narrow pools, so that collisions, priority choices and the 4 GB codes come up often. A behavioural model checks every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ADDR_W   = 32;
  localparam int PGOFF_W  = 12;
  localparam int VPN_W    = ADDR_W - PGOFF_W;
  localparam int TAG_W    = 8;
  localparam int SIZE_W   = 4;
  localparam int MAX_CODE = VPN_W / 2;

  typedef struct packed {
    logic              valid;
    logic              space;
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic [VPN_W-1:0]  epn;
    logic [VPN_W-1:0]  rpn;
  } tlb_ent_t;

  localparam int ENT_W = $bits(tlb_ent_t);

  // 1 marks a page-number bit that takes part in the compare
  function automatic logic [VPN_W-1:0] page_keep(input logic [SIZE_W-1:0] code);
    logic [VPN_W-1:0] m;
    int sh;
    sh = (int'(code) > MAX_CODE) ? VPN_W : 2 * int'(code);
    for (int j = 0; j < VPN_W; j++) m[j] = (j >= sh);
    return m;
  endfunction
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  tlb_ent_t                  wr_ent,
  output tlb_ent_t [NUM_ENT-1:0]    ent_q
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    logic             sel;
    logic             v_d, v_q;
    logic [ENT_W-2:0] pay_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      v_d = v_q;
      if (sel) v_d = wr_ent.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (sel) pay_q <= wr_ent[ENT_W-2:0];
    end

    assign ent_q[g] = {v_q, pay_q};
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_ent))) else $error("write lost"); // R2
endmodule

// File: rtl/xlat_entry_match.sv
module xlat_entry_match
  import xlat_pkg::*;
(
  input  tlb_ent_t           ent,
  input  logic [ADDR_W-1:0]  ea,
  input  logic               cur_as,
  input  logic [TAG_W-1:0]   cur_pid,
  output logic               match,
  output logic [VPN_W-1:0]   rpage
);
  logic [VPN_W-1:0] keep;
  logic [VPN_W-1:0] ea_vpn;
  logic             tag_ok, page_ok;

  always_comb begin
    keep    = page_keep(ent.size);
    ea_vpn  = ea[ADDR_W-1:PGOFF_W];
    tag_ok  = (ent.tag == '0) || (ent.tag == cur_pid);
    page_ok = ((ea_vpn ^ ent.epn) & keep) == '0;
    match   = ent.valid && (ent.space == cur_as) && tag_ok && page_ok;
    rpage   = (ent.rpn & keep) | (ea_vpn & ~keep);
  end
endmodule

// File: rtl/xlat_hit_select.sv
module xlat_hit_select
  import xlat_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]            match_vec,
  input  logic [NUM_ENT-1:0][VPN_W-1:0] rpage_vec,
  input  logic [PGOFF_W-1:0]            ea_off,
  output logic                          hit,
  output logic                          multi_hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic [ADDR_W-1:0]             real_addr
);
  logic [VPN_W-1:0] page_sel;
  logic             seen;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    page_sel = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
        page_sel = rpage_vec[i];
      end
    end
  end

  always_comb begin
    seen      = 1'b0;
    multi_hit = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match_vec[i]) begin
        if (seen) multi_hit = 1'b1;
        seen = 1'b1;
      end
    end
  end

  assign real_addr = hit ? {page_sel, ea_off} : '0;
endmodule

// File: rtl/xlat_tlb_top.sv
module xlat_tlb_top
  import xlat_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    lk_ea,
  input  logic                 lk_is_data,
  input  logic                 lk_ispace,
  input  logic                 lk_dspace,
  input  logic [TAG_W-1:0]     lk_pid,
  output logic                 hit,
  output logic                 multi_hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [ADDR_W-1:0]    real_addr,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_valid,
  input  logic                 wr_space,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [SIZE_W-1:0]    wr_size,
  input  logic [VPN_W-1:0]     wr_epn,
  input  logic [VPN_W-1:0]     wr_rpn
);
  tlb_ent_t                      wr_ent;
  tlb_ent_t [NUM_ENT-1:0]        ent_q;
  logic [NUM_ENT-1:0]            match_vec;
  logic [NUM_ENT-1:0][VPN_W-1:0] rpage_vec;
  logic                          cur_as;

  assign wr_ent = '{valid: wr_valid, space: wr_space, tag: wr_tag,
                    size: wr_size, epn: wr_epn, rpn: wr_rpn};
  assign cur_as = lk_is_data ? lk_dspace : lk_ispace;

  xlat_entry_store #(.NUM_ENT(NUM_ENT)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .ent_q  (ent_q)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    xlat_entry_match u_match (
      .ent     (ent_q[g]),
      .ea      (lk_ea),
      .cur_as  (cur_as),
      .cur_pid (lk_pid),
      .match   (match_vec[g]),
      .rpage   (rpage_vec[g])
    );
  end

  xlat_hit_select #(.NUM_ENT(NUM_ENT)) u_sel (
    .match_vec (match_vec),
    .rpage_vec (rpage_vec),
    .ea_off    (lk_ea[PGOFF_W-1:0]),
    .hit       (hit),
    .multi_hit (multi_hit),
    .hit_idx   (hit_idx),
    .real_addr (real_addr)
  );

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (real_addr == '0 && !multi_hit && hit_idx == '0)) else $error("miss not quiet"); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (real_addr[PGOFF_W-1:0] == lk_ea[PGOFF_W-1:0])) else $error("offset altered"); // R7
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ent_q[hit_idx].valid) else $error("invalid slot hit"); // R3
  AST_HIT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ent_q[hit_idx].space == (lk_is_data ? lk_dspace : lk_ispace))) else $error("space"); // R4
  AST_HIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ent_q[hit_idx].tag == '0 || ent_q[hit_idx].tag == lk_pid)) else $error("owner"); // R5
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> (hit && $countones(match_vec) > 1)) else $error("multi"); // R9
endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_ea;
  logic        lk_is_data, lk_ispace, lk_dspace;
  logic [7:0]  lk_pid;
  logic        hit, multi_hit;
  logic [3:0]  hit_idx;
  logic [31:0] real_addr;
  logic        wr_en, wr_valid, wr_space;
  logic [3:0]  wr_idx, wr_size;
  logic [7:0]  wr_tag;
  logic [19:0] wr_epn, wr_rpn;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural model
  bit       m_v[16];
  bit       m_sp[16];
  int       m_tag[16], m_size[16];
  bit [31:0] m_epa[16], m_rpa[16];

  always #(CLK_P/2) clk = ~clk;

  xlat_tlb_top dut_i (
    .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .lk_is_data(lk_is_data),
    .lk_ispace(lk_ispace), .lk_dspace(lk_dspace), .lk_pid(lk_pid),
    .hit(hit), .multi_hit(multi_hit), .hit_idx(hit_idx), .real_addr(real_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_space(wr_space),
    .wr_tag(wr_tag), .wr_size(wr_size), .wr_epn(wr_epn), .wr_rpn(wr_rpn));

  task automatic model(output bit e_hit, output bit e_multi, output int e_idx,
                       output bit [31:0] e_ra);
    int found = 0;
    e_hit = 0; e_multi = 0; e_idx = 0; e_ra = 0;
    for (int i = 0; i < 16; i++) begin
      int off = (m_size[i] >= 10) ? 32 : 12 + 2 * m_size[i];
      bit [31:0] msk = (off == 32) ? 32'h0 : (32'hFFFF_FFFF << off);
      bit as = lk_is_data ? lk_dspace : lk_ispace;
      if (m_v[i] && m_sp[i] == as && (m_tag[i] == 0 || m_tag[i] == int'(lk_pid)) &&
          ((lk_ea ^ m_epa[i]) & msk) == 0) begin
        found++;
        if (found == 1) begin
          e_hit = 1; e_idx = i;
          e_ra = (m_rpa[i] & msk) | (lk_ea & ~msk);
        end
      end
    end
    e_multi = (found > 1);
  endtask

  // compare now, then let one clock edge pass and mirror it in the model
  task automatic step(string req);
    bit e_hit, e_multi; int e_idx; bit [31:0] e_ra;
    #1;
    model(e_hit, e_multi, e_idx, e_ra);
    tests++;
    if (hit !== e_hit || multi_hit !== e_multi || int'(hit_idx) != e_idx || real_addr !== e_ra) begin
      fails++;
      $display("FAIL %s: actual hit=%0b multi=%0b idx=%0d ra=%h expected hit=%0b multi=%0b idx=%0d ra=%h",
               req, hit, multi_hit, hit_idx, real_addr, e_hit, e_multi, e_idx, e_ra);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end else if (wr_en) begin
      m_v[wr_idx] = wr_valid; m_sp[wr_idx] = wr_space; m_tag[wr_idx] = int'(wr_tag);
      m_size[wr_idx] = int'(wr_size);
      m_epa[wr_idx] = {wr_epn, 12'h0}; m_rpa[wr_idx] = {wr_rpn, 12'h0};
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put(input int idx, input bit v, input bit sp, input int tag,
                     input int size, input bit [19:0] epn, input bit [19:0] rpn);
    wr_en = 1; wr_idx = 4'(idx); wr_valid = v; wr_space = sp; wr_tag = 8'(tag);
    wr_size = 4'(size); wr_epn = epn; wr_rpn = rpn;
  endtask

  task automatic look(input bit [31:0] ea, input bit isd, input bit isp,
                      input bit dsp, input int pid);
    lk_ea = ea; lk_is_data = isd; lk_ispace = isp; lk_dspace = dsp; lk_pid = 8'(pid);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R10: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_sp[i] = 0; m_tag[i] = 0; m_size[i] = 0; m_epa[i] = 0; m_rpa[i] = 0;
    end
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_space = 0; wr_tag = 0;
    wr_size = 0; wr_epn = 0; wr_rpn = 0;
    look(32'h1234_5678, 0, 0, 0, 5);
    @(negedge clk);
    put(3, 1, 0, 5, 0, 20'h12345, 20'hABCDE);   // write during reset must be dropped
    step("R1 reset blocks write");
    step("R1 reset state");
    rst_n = 1;
    step("R1 empty after reset");

    put(3, 1, 0, 5, 0, 20'h12345, 20'hABCDE);
    step("R8 miss before write");
    step("R2 R7 hit 4KB idx3");                  // expect ra ABCDE678
    look(32'h1234_5678, 0, 0, 0, 6);
    step("R5 wrong pid misses");
    put(4, 1, 0, 0, 0, 20'h22222, 20'h33333);
    look(32'h2222_2ABC, 0, 0, 0, 9);
    step("R5 before global write");
    step("R5 global tag hits any pid");
    look(32'h1234_5678, 1, 0, 1, 5);
    step("R4 data uses dspace miss");
    look(32'h1234_5678, 1, 1, 0, 5);
    step("R4 data uses dspace hit");
    look(32'h1234_5678, 0, 1, 0, 5);
    step("R4 fetch uses ispace miss");
    look(32'h1234_5679, 0, 0, 0, 5);
    step("R10 same-cycle follow");
    put(3, 0, 0, 5, 0, 20'h12345, 20'hABCDE);
    step("R3 before invalidate");
    step("R3 invalid slot ignored");

    put(5, 1, 0, 0, 2, 20'h4000F, 20'h9000F);    // 64 KB page
    look(32'h4000_ABCD, 0, 0, 0, 1);
    step("R6 before large page");
    step("R6 R7 64KB page ra 9000ABCD");
    put(7, 1, 0, 0, 0, 20'h4000A, 20'h77777);
    step("R9 before overlap");
    step("R9 lowest index wins multi");
    look(32'h4000_BBCD, 0, 0, 0, 1);
    step("R9 single match no multi");
    put(9, 1, 1, 0, 10, 20'hFFFFF, 20'h00000);   // 4 GB page, space 1
    look(32'hDEAD_BEEF, 0, 1, 0, 3);
    step("R6 before 4GB page");
    step("R6 4GB code 10 ra=ea");
    put(9, 1, 1, 0, 15, 20'h12345, 20'h54321);
    step("R6 code 15 treated as 4GB");
    step("R6 code 15 ra=ea");
    put(9, 0, 1, 0, 15, 20'h0, 20'h0);
    step("R2 other slots kept");

    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 2) == 0) begin
        put(int'($urandom_range(0, 15)), ($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 2)),
            ($urandom_range(0, 15) == 0) ? int'($urandom_range(10, 15)) : int'($urandom_range(0, 3)),
            20'h40000 + 20'($urandom_range(0, 7)), 20'($urandom));
      end
      if ($urandom_range(0, 7) == 0)
        look($urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
      else
        look({20'h40000 + 20'($urandom_range(0, 7)), 12'($urandom)},
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
      step("R9 R6 R4 R5 random");
    end
    finish_run();
  end
endmodule